// File: doc/BRIEF.md
# Fault-Detecting Iterative AES-128 Encryptor

This block encrypts one 128-bit block under a 128-bit key with AES-128. It runs one full round per clock. The round key for each round is derived in the same cycle as that round, so no key storage is needed. To make fault injection harder to exploit, each block is encrypted twice from the same latched inputs. The result is released only if both passes agree. Before any computation starts, the block waits a number of idle cycles taken from a random input. This spreads the timing of the sensitive rounds from one run to the next.

A start pulse in the idle state latches the plaintext, the key and the 4-bit delay value. A fixed number of cycles later, set by the delay, the block gives one of two results. Either it pulses the valid flag with the ciphertext on the output bus, or it pulses the fault flag and keeps the bus at zero. Between results the bus always reads zero.

Top module: `aes_fd_top`

## Requirements
- R1: A synchronous active-high reset, including one applied in the middle of a run, clears ct_o, valid_o and fault_o and returns the block to idle; no result from the interrupted run appears afterwards.
- R2: ct_o is standard AES-128 encryption of plain_i under key_i, where byte 0 of each 128-bit word is bits [127:120] and byte i fills state row i mod 4, column i div 4.
- R3: valid_o is a one-cycle pulse, ct_o carries the ciphertext only in that cycle, and ct_o is all zeros in every other cycle.
- R4: With d the value of rnd_i sampled with the accepted start, valid_o (or fault_o) is high in the cycle after the d+21st rising edge following the edge that accepted start. These cycles are made up of d idle cycles, one load cycle and two passes of ten rounds each.
- R5: rnd_i is sampled only when start is accepted; changing it during a run does not alter that run's latency.
- R6: start_i is ignored while a run is in progress; new plaintext, key or delay presented with it neither change the current result nor queue a second run.
- R7: If the second pass gives a result different from the first, fault_o pulses for one cycle, valid_o stays low and ct_o stays zero; the next run behaves normally.
- R8: valid_o and fault_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| plain_i | input | 128 | Plaintext block, byte 0 in bits [127:120] |
| key_i | input | 128 | Cipher key, byte 0 in bits [127:120] |
| rnd_i | input | 4 | Random count of idle cycles to insert before computing |
| ct_o | output | 128 | Ciphertext during the valid cycle, zero otherwise |
| valid_o | output | 1 | One-cycle pulse: the two passes agreed |
| fault_o | output | 1 | One-cycle pulse: the two passes disagreed |

## Verification
The latency property assumes two things: that each start is a pulse the checker can match to its result, and that rnd_i is steady in the cycle where start is accepted. The bench drives start and rnd_i at the falling edge, so both are stable around the sampling edge. The bench changes rnd_i, plaintext and key in the middle of runs only together with a start pulse that must be ignored. The one fault scenario corrupts the round state for a single cycle during the second pass. This models a transient upset and matches the only case the comparison is built to catch.

// File: rtl/aes_fd_pkg.sv
package aes_fd_pkg;

    localparam int BLK_W  = 128;
    localparam int NB     = BLK_W / 8;
    localparam int ROUNDS = 10;
    localparam int DLY_W  = 4;
    localparam int RND_W  = $clog2(ROUNDS + 1);

    typedef logic [BLK_W-1:0] blk_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_WAIT,
        PH_RUN
    } phase_e;

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254; zero maps to zero
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] p2, p3, p12, p15, p240;
        p2   = gf_mul(a, a);
        p3   = gf_mul(p2, a);
        p12  = gf_mul(gf_mul(p3, p3), gf_mul(p3, p3));
        p15  = gf_mul(p12, p3);
        p240 = gf_mul(p15, p15);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        p240 = gf_mul(p240, p240);
        return gf_mul(gf_mul(p240, p12), p2);
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int k);
        return (b << k) | (b >> (8 - k));
    endfunction

    function automatic logic [7:0] sbox(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

endpackage

// File: rtl/aes_fd_round.sv
module aes_fd_round
    import aes_fd_pkg::*;
(
    input  blk_t state_i,
    input  blk_t rkey_i,
    input  logic final_i,
    output blk_t state_o
);

    logic [7:0] sb [NB];
    logic [7:0] sr [NB];
    logic [7:0] mc [NB];

    for (genvar gi = 0; gi < NB; gi++) begin : g_sub
        assign sb[gi] = sbox(state_i[BLK_W-1-8*gi -: 8]);
    end

    for (genvar gc = 0; gc < 4; gc++) begin : g_col
        for (genvar gr = 0; gr < 4; gr++) begin : g_row
            assign sr[4*gc+gr] = sb[4*((gc+gr)%4)+gr];
        end
        logic [7:0] a0, a1, a2, a3;
        assign a0 = sr[4*gc+0];
        assign a1 = sr[4*gc+1];
        assign a2 = sr[4*gc+2];
        assign a3 = sr[4*gc+3];
        assign mc[4*gc+0] = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
        assign mc[4*gc+1] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
        assign mc[4*gc+2] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
        assign mc[4*gc+3] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
    end

    for (genvar gi = 0; gi < NB; gi++) begin : g_ark
        assign state_o[BLK_W-1-8*gi -: 8] =
            (final_i ? sr[gi] : mc[gi]) ^ rkey_i[BLK_W-1-8*gi -: 8];
    end

endmodule

// File: rtl/aes_fd_keystep.sv
module aes_fd_keystep
    import aes_fd_pkg::*;
(
    input  blk_t       key_i,
    input  logic [7:0] rcon_i,
    output blk_t       key_o
);

    localparam int NW = BLK_W / 32;

    logic [31:0] w   [NW];
    logic [31:0] nw  [NW];
    logic [31:0] rot;
    logic [31:0] mix;

    for (genvar gw = 0; gw < NW; gw++) begin : g_split
        assign w[gw] = key_i[BLK_W-1-32*gw -: 32];
        assign key_o[BLK_W-1-32*gw -: 32] = nw[gw];
    end

    assign rot = {w[NW-1][23:0], w[NW-1][31:24]};
    assign mix = {sbox(rot[31:24]) ^ rcon_i, sbox(rot[23:16]),
                  sbox(rot[15:8]), sbox(rot[7:0])};

    assign nw[0] = w[0] ^ mix;
    for (genvar gw = 1; gw < NW; gw++) begin : g_chain
        assign nw[gw] = w[gw] ^ nw[gw-1];
    end

endmodule

// File: rtl/aes_fd_top.sv
module aes_fd_top
    import aes_fd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [BLK_W-1:0] plain_i,
    input  logic [BLK_W-1:0] key_i,
    input  logic [DLY_W-1:0] rnd_i,
    output logic [BLK_W-1:0] ct_o,
    output logic             valid_o,
    output logic             fault_o
);

    phase_e           phase_q;
    logic [DLY_W-1:0] cnt_q;
    logic [RND_W-1:0] rnd_q;
    logic             pass_q;
    logic [7:0]       rcon_q;
    blk_t             pt_q, key_q, data_q, rk_q, res0_q, ct_q;
    logic             valid_q, fault_q;
    blk_t             rk_next, data_next;
    logic             last_rnd;

    assign last_rnd = (rnd_q == RND_W'(ROUNDS));

    aes_fd_keystep u_key (
        .key_i  (rk_q),
        .rcon_i (rcon_q),
        .key_o  (rk_next)
    );

    aes_fd_round u_round (
        .state_i (data_q),
        .rkey_i  (rk_next),
        .final_i (last_rnd),
        .state_o (data_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            rnd_q   <= '0;
            pass_q  <= 1'b0;
            rcon_q  <= 8'h00;
            pt_q    <= '0;
            key_q   <= '0;
            data_q  <= '0;
            rk_q    <= '0;
            res0_q  <= '0;
            ct_q    <= '0;
            valid_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            ct_q    <= '0;
            valid_q <= 1'b0;
            fault_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        pt_q    <= plain_i;
                        key_q   <= key_i;
                        cnt_q   <= rnd_i;
                        pass_q  <= 1'b0;
                        phase_q <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (cnt_q == '0) begin
                        data_q  <= pt_q ^ key_q;
                        rk_q    <= key_q;
                        rcon_q  <= 8'h01;
                        rnd_q   <= RND_W'(1);
                        phase_q <= PH_RUN;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                PH_RUN: begin
                    data_q <= data_next;
                    rk_q   <= rk_next;
                    rcon_q <= xtime(rcon_q);
                    rnd_q  <= rnd_q + 1'b1;
                    if (last_rnd) begin
                        if (!pass_q) begin
                            res0_q <= data_next;
                            pass_q <= 1'b1;
                            data_q <= pt_q ^ key_q;
                            rk_q   <= key_q;
                            rcon_q <= 8'h01;
                            rnd_q  <= RND_W'(1);
                        end else begin
                            if (data_next == res0_q) begin
                                ct_q    <= data_next;
                                valid_q <= 1'b1;
                            end else begin
                                fault_q <= 1'b1;
                            end
                            phase_q <= PH_IDLE;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign ct_o    = ct_q;
    assign valid_o = valid_q;
    assign fault_o = fault_q;

endmodule

// File: rtl/aes_fd_chk.sv
module aes_fd_chk
    import aes_fd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [DLY_W-1:0] rnd_i,
    input logic [BLK_W-1:0] ct_o,
    input logic             valid_o,
    input logic             fault_o
);

    logic             busy_q;
    logic [DLY_W-1:0] d_q;
    logic [5:0]       cyc_q;
    logic             free_now;

    assign free_now = !busy_q || valid_o || fault_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            d_q    <= '0;
            cyc_q  <= '0;
        end else if (free_now && start_i) begin
            busy_q <= 1'b1;
            d_q    <= rnd_i;
            cyc_q  <= '0;
        end else if (valid_o || fault_o) begin
            busy_q <= 1'b0;
        end else if (busy_q && cyc_q != 6'h3f) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!valid_o && !fault_o && ct_o == '0));

    a_r3_zero_bus: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> ct_o == '0);

    a_r3_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    a_r7_fault_pulse: assert property (@(posedge clk) disable iff (rst)
        fault_o |=> !fault_o);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && fault_o));

    a_r4_latency: assert property (@(posedge clk) disable iff (rst)
        (valid_o || fault_o) |-> (busy_q && cyc_q == 6'(d_q) + 6'd21));

endmodule

bind aes_fd_top aes_fd_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .rnd_i   (rnd_i),
    .ct_o    (ct_o),
    .valid_o (valid_o),
    .fault_o (fault_o)
);

// File: tb/sim_aes_fd_top.sv
`timescale 1ns/1ps
module sim_aes_fd_top;

    typedef struct packed {
        logic [127:0] key;
        logic [127:0] pt;
        logic [127:0] ct;
        logic [3:0]   dly;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a, 4'd0},
        '{128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h3243f6a8885a308d313198a2e0370734,
          128'h3925841d02dc09fbdc118597196a0b32, 4'd15},
        '{128'h00000000000000000000000000000000, 128'h00000000000000000000000000000000,
          128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 4'd7},
        '{128'h000102030405060708090a0b0c0d0e0f, 128'h00112233445566778899aabbccddeeff,
          128'h69c4e0d86a7b0430d8cdb78070b4c55a, 4'd3}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [127:0] plain_i = '0;
    logic [127:0] key_i = '0;
    logic [3:0]   rnd_i = '0;
    logic [127:0] ct_o;
    logic         valid_o;
    logic         fault_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    aes_fd_top u0 (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .plain_i (plain_i),
        .key_i   (key_i),
        .rnd_i   (rnd_i),
        .ct_o    (ct_o),
        .valid_o (valid_o),
        .fault_o (fault_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Leaves the bench at the falling edge after the accepting edge.
    task automatic launch(input logic [127:0] k, input logic [127:0] p, input logic [3:0] d);
        @(negedge clk);
        key_i   = k;
        plain_i = p;
        rnd_i   = d;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Counts rising edges until a result is seen; optional ignored start at edge 5.
    task automatic wait_done(input bit disturb, output int n, output bit gv, output bit gf,
                             output logic [127:0] ct, output bit bus_dirty);
        n = 0; gv = 0; gf = 0; ct = '0; bus_dirty = 0;
        while (n < 80) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start_i = 1'b0;
            if (valid_o || fault_o) begin
                gv = valid_o; gf = fault_o; ct = ct_o;
                break;
            end
            if (ct_o != '0) bus_dirty = 1;
            if (disturb && n == 5) begin
                start_i = 1'b1;
                plain_i = ~plain_i;
                key_i   = ~key_i;
                rnd_i   = 4'hf;
            end
        end
    endtask

    task automatic quiet(input int cycles, output bit seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (valid_o || fault_o || ct_o != '0) seen = 1;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        int n;
        bit gv, gf, dirty, seen;
        logic [127:0] ct;

        repeat (3) @(negedge clk);
        // R1: state under reset
        chk(valid_o == 0 && fault_o == 0 && ct_o == '0, "R1", "outputs during reset",
            {ct_o[125:0], valid_o, fault_o}, '0);
        rst = 1'b0;

        // R2 R3 R4 R8: vector table
        for (int v = 0; v < NV; v++) begin
            launch(VECS[v].key, VECS[v].pt, VECS[v].dly);
            wait_done(1'b0, n, gv, gf, ct, dirty);
            chk(gv && !gf, "R8", "valid without fault", {gv, gf}, 2'b10);
            chk(ct == VECS[v].ct, "R2", "ciphertext", ct, VECS[v].ct);
            chk(n == int'(VECS[v].dly) + 21, "R4", "latency", n, int'(VECS[v].dly) + 21);
            chk(!dirty, "R3", "bus zero while busy", dirty, 0);
            @(negedge clk);
            chk(!valid_o && ct_o == '0, "R3", "pulse ends after one cycle",
                {ct_o[126:0], valid_o}, '0);
        end

        // R5 R6: start and new inputs during a run are ignored
        launch(VECS[1].key, VECS[1].pt, 4'd2);
        wait_done(1'b1, n, gv, gf, ct, dirty);
        chk(gv && ct == VECS[1].ct, "R6", "result under ignored start", ct, VECS[1].ct);
        chk(n == 23, "R5", "latency keeps sampled delay", n, 23);
        quiet(40, seen);
        chk(!seen, "R6", "no queued second run", seen, 0);

        // R1: reset in the middle of a run
        launch(VECS[0].key, VECS[0].pt, 4'd0);
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!valid_o && !fault_o && ct_o == '0, "R1", "outputs after mid-run reset",
            {ct_o[125:0], valid_o, fault_o}, '0);
        rst = 1'b0;
        quiet(40, seen);
        chk(!seen, "R1", "aborted run leaves no result", seen, 0);

        // R7: transient corruption of the round state in the second pass
        launch(VECS[0].key, VECS[0].pt, 4'd0);
        repeat (14) @(posedge clk);
        #1 force u0.data_q = 128'h5a5a5a5a_a5a5a5a5_0f0f0f0f_f0f0f0f0;
        @(posedge clk);
        #1 release u0.data_q;
        wait_done(1'b0, n, gv, gf, ct, dirty);
        chk(gf && !gv, "R7", "fault flagged, no valid", {gv, gf}, 2'b01);
        chk(ct == '0, "R7", "bus zero on fault", ct, '0);
        chk(n == 6, "R7", "fault at normal latency", n + 15, 21);
        @(negedge clk);
        chk(!fault_o, "R7", "fault pulse one cycle", fault_o, 0);

        // R7: recovery after a fault
        launch(VECS[2].key, VECS[2].pt, 4'd1);
        wait_done(1'b0, n, gv, gf, ct, dirty);
        chk(gv && !gf && ct == VECS[2].ct, "R7", "clean run after fault", ct, VECS[2].ct);
        chk(n == 22, "R4", "latency after fault", n, 22);

        summary();
    end

endmodule